// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits after a clock divider. It turns one free-running source clock into a group of gated copies and one always-on copy. Two asynchronous active-low requests control them. The stop request halts only the gated group. The power-down request halts every output, including the always-on copy.

Each request passes through a synchronizer clocked by the source clock before it can affect any output. Every enable change is taken on a falling edge of the source clock. Because of this, an output never glitches, stopped outputs rest low, and a restart begins with a full high phase. Once the gated group has been switched on, it stays on for a set minimum number of source cycles before a stop request can take effect again. Power-down ignores that window and acts at once.

Top module: `clkgate_ctrl`

## Requirements
- R1: `stop_req_n` is synchronized through two source-clock flops. After it is driven low between two rising edges, the gated outputs still deliver exactly three more high pulses, provided the minimum-on window has already elapsed.
- R2: While stopped, every gated output is held low. Each halt begins on a falling edge, so the last pulse is never truncated.
- R3: Every high pulse on any output lasts exactly half a source period. This includes the first pulse after a restart. After a stop release, the first gated pulse comes on the fourth rising edge.
- R4: Once the gated outputs have been restarted, they deliver at least `MIN_ON_CYCLES` (default 10) pulses before a stop can halt them. A stop that is already pending when the window closes halts them after exactly that many pulses.
- R5: `free_clk` keeps running whatever the state of `stop_req_n`.
- R6: `pwrdn_req_n` is synchronized through two flops. All outputs, including `free_clk`, stop low on the falling edge that follows the second flop capturing the request. A request driven between rising edges therefore lets exactly two more `free_clk` pulses through.
- R7: Power-down takes priority over the stop request and over the minimum-on window. A power-down that arrives inside the window halts the gated outputs before the window has elapsed.
- R8: While `rst_n` is low, every output is low.
- R9: All bits of `gated_clk` always carry the same value.
- R10: After `pwrdn_req_n` is released, `free_clk` delivers its first pulse on the third rising edge. If `stop_req_n` is high, the gated outputs follow on the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Free-running source clock of the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request for the gated group |
| pwrdn_req_n | input | 1 | Asynchronous active-low power-down request for all outputs |
| gated_clk | output | NUM_GATED | Gated copies of the source clock |
| free_clk | output | 1 | Copy of the source clock that ignores the stop request |

## Verification
The embedded properties are checked on every cycle. They confirm that:
- a registered power-down forces all enables off;
- a stopped controller leaves the gated enables off;
- the gated enables always agree with each other;
- the run state only drops once the minimum-on count is reached, unless power-down is active;
- the free enable returns on the falling edge that follows a power-down release.

Some behaviour is visible only at the pins, so only the bench scenarios can show it:
- the exact pulse counts that expose the synchronizer depth;
- the full-width first pulse after a restart;
- the ten-pulse bursts produced by rapid stop requests;
- a power-down that cuts a minimum-on window short.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_e;

    // Width of a counter that must hold values 0 .. n-1.
    function automatic int unsigned cnt_bits(input int unsigned n);
        int unsigned w;
        w = $clog2(n);
        if (w < 1) w = 1;
        return w;
    endfunction

endpackage

// File: rtl/clkgate_req_sync.sv
module clkgate_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    output logic en_o,
    output logic gclk
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_req;
    end

    // The enable is taken only while clk is low, so gclk cannot glitch.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;
    assign gclk = clk & en_q;
endmodule

// File: rtl/clkgate_stop_ctrl.sv
module clkgate_stop_ctrl
    import clkgate_pkg::*;
#(
    parameter int unsigned MIN_ON = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_sync,
    input  logic pd_sync,
    output logic run_o
);
    localparam int unsigned   CW      = cnt_bits(MIN_ON);
    localparam logic [CW-1:0] CNT_TOP = CW'(MIN_ON - 1);

    typedef struct packed {
        gate_e         run;
        logic [CW-1:0] cnt;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pd_sync) begin
            s_d.run = GATE_OFF;
            s_d.cnt = '0;
        end else if (s_q.run == GATE_OFF) begin
            if (!stop_sync) begin
                s_d.run = GATE_ON;
                s_d.cnt = '0;
            end
        end else if (s_q.cnt == CNT_TOP) begin
            if (stop_sync) s_d.run = GATE_OFF;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{run: GATE_OFF, cnt: '0};
        else        s_q <= s_d;
    end

    assign run_o = (s_q.run == GATE_ON);

    // R4
    no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_o) && !$past(pd_sync)) |-> ($past(s_q.cnt) == CNT_TOP));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_TOP);

    // R1
    clean_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> (!$past(stop_sync) && !$past(pd_sync)));
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
    parameter int unsigned NUM_GATED     = 6,
    parameter int unsigned MIN_ON_CYCLES = 10,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic                 src_clk,
    input  logic                 rst_n,
    input  logic                 stop_req_n,
    input  logic                 pwrdn_req_n,
    output logic [NUM_GATED-1:0] gated_clk,
    output logic                 free_clk
);
    logic                 stop_q, pd_q, run;
    logic                 grp_req;
    logic [NUM_GATED-1:0] gate_en;
    logic                 free_en;

    clkgate_req_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(src_clk), .rst_n(rst_n), .din(~stop_req_n), .dout(stop_q)
    );

    clkgate_req_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(src_clk), .rst_n(rst_n), .din(~pwrdn_req_n), .dout(pd_q)
    );

    clkgate_stop_ctrl #(.MIN_ON(MIN_ON_CYCLES)) u_ctrl (
        .clk(src_clk), .rst_n(rst_n), .stop_sync(stop_q),
        .pd_sync(pd_q), .run_o(run)
    );

    assign grp_req = run & ~pd_q;

    for (genvar i = 0; i < NUM_GATED; i++) begin : g_cell
        clkgate_cell u_cell (
            .clk(src_clk), .rst_n(rst_n), .en_req(grp_req),
            .en_o(gate_en[i]), .gclk(gated_clk[i])
        );
    end

    clkgate_cell u_free (
        .clk(src_clk), .rst_n(rst_n), .en_req(~pd_q),
        .en_o(free_en), .gclk(free_clk)
    );

    // R6
    pd_gate_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        pd_q |-> (gate_en == '0 && !free_en));

    // R2
    stopped_low_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        !run |-> (gate_en == '0));

    // R9
    lockstep_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        (gate_en == '0) || (gate_en == '1));

    // R10
    free_resume_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
        $fell(pd_q) |-> free_en);
endmodule

// File: tb/sim_clkgate_ctrl.sv
`timescale 1ns/1ps
module sim_clkgate_ctrl;
    localparam int NG = 6;

    logic          src_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_req_n = 1'b1;
    logic          pwrdn_req_n = 1'b1;
    logic [NG-1:0] gated_clk;
    logic          free_clk;

    int  n_chk = 0, n_fail = 0;
    int  gcnt = 0, fcnt = 0;
    int  bad_w = 0, bad_mix = 0;
    time t_g = 0, t_f = 0;
    bit  done = 0;

    clkgate_ctrl #(.NUM_GATED(NG)) u0 (
        .src_clk(src_clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
        .pwrdn_req_n(pwrdn_req_n), .gated_clk(gated_clk), .free_clk(free_clk)
    );

    always #10 src_clk = ~src_clk;

    always @(posedge gated_clk[0]) begin gcnt++; t_g = $time; end
    always @(negedge gated_clk[0]) if ($time - t_g != 10) bad_w++;
    always @(posedge free_clk) begin fcnt++; t_f = $time; end
    always @(negedge free_clk) if ($time - t_f != 10) bad_w++;
    always @(posedge src_clk) begin
        #2;
        if (gated_clk != '0 && gated_clk != '1) bad_mix++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts pulses over n rising edges, starting right after a falling-edge drive.
    task automatic window(input int n, output int g, output int f);
        int g0 = gcnt;
        int f0 = fcnt;
        repeat (n) @(posedge src_clk);
        #5;
        g = gcnt - g0;
        f = fcnt - f0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge src_clk);
        #5;
        check(gated_clk == '0, "R8 gated low in reset", int'(gated_clk), 0);
        check(free_clk == 1'b0, "R8 free low in reset", int'(free_clk), 0);
        @(negedge src_clk) rst_n = 1'b1;
    endtask

    task automatic t_run();
        int g, f;
        repeat (15) @(negedge src_clk);
        window(20, g, f);
        check(g == 20, "R3 gated running", g, 20);
        check(f == 20, "R5 free running", f, 20);
    endtask

    task automatic t_stop();
        int g, f, bad;
        bad = 0;
        @(negedge src_clk) stop_req_n = 1'b0;
        window(10, g, f);
        check(g == 3, "R1 pulses after stop", g, 3);
        for (int i = 0; i < 20; i++) begin
            @(posedge src_clk); #5;
            if (gated_clk != '0) bad++;
        end
        check(bad == 0, "R2 gated parked low", bad, 0);
        @(negedge src_clk);
        window(20, g, f);
        check(f == 20, "R5 free ignores stop", f, 20);
    endtask

    task automatic t_restart();
        int g, f;
        @(negedge src_clk) stop_req_n = 1'b1;
        window(30, g, f);
        check(g == 27, "R3 restart latency", g, 27);
    endtask

    task automatic t_rapid();
        int g, f;
        int g0;
        @(negedge src_clk) stop_req_n = 1'b0;
        repeat (20) @(negedge src_clk);
        // Two-cycle release, then the stop request again.
        stop_req_n = 1'b1;
        g0 = gcnt;
        repeat (2) @(negedge src_clk);
        stop_req_n = 1'b0;
        window(40, g, f);
        check(gcnt - g0 == 10, "R4 min-on after 2-cycle release", gcnt - g0, 10);
        for (int b = 0; b < 2; b++) begin
            @(negedge src_clk) stop_req_n = 1'b1;
            g0 = gcnt;
            @(negedge src_clk) stop_req_n = 1'b0;
            window(40, g, f);
            check(gcnt - g0 == 10, "R4 min-on after 1-cycle release", gcnt - g0, 10);
        end
    endtask

    task automatic t_pd();
        int g, f, bad;
        int g0, f0;
        bad = 0;
        @(negedge src_clk) stop_req_n = 1'b1;
        g0 = gcnt;
        f0 = fcnt;
        repeat (5) @(negedge src_clk);
        pwrdn_req_n = 1'b0;
        window(15, g, f);
        check(gcnt - g0 == 4, "R7 power-down cuts min-on window", gcnt - g0, 4);
        check(fcnt - f0 == 7, "R6 free stops after sync", fcnt - f0, 7);
        for (int i = 0; i < 20; i++) begin
            @(posedge src_clk); #5;
            if (gated_clk != '0 || free_clk != 1'b0) bad++;
        end
        check(bad == 0, "R6 all outputs low in power-down", bad, 0);
    endtask

    task automatic t_pd_release();
        int g, f;
        @(negedge src_clk) pwrdn_req_n = 1'b1;
        window(20, g, f);
        check(f == 18, "R10 free resumes first", f, 18);
        check(g == 17, "R10 gated resumes next", g, 17);
    endtask

    initial begin
        t_reset();
        t_run();
        t_stop();
        t_restart();
        t_rapid();
        t_pd();
        t_pd_release();
        check(bad_w == 0, "R3 pulse widths", bad_w, 0);
        check(bad_mix == 0, "R9 outputs in lockstep", bad_mix, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule